// File: doc/BRIEF.md
# SM3 Message Expander

This block turns one 512-bit padded message block into the word streams that the SM3 compression rounds consume. A single-cycle `load` pulse captures the block. The block then emits one pair per clock: the expanded word `wj` and the paired word `wpj`, which is `wj` XOR the word four positions later. Pairs leave in index order 0 to 63, and `out_valid` marks each one.

Inside, a 16-word window shifts by one word per cycle. During the first sixteen steps it rotates the loaded block words through its tail. After that it appends words produced by the SM3 expansion recurrence. A run takes 68 internal steps. The first four steps only build the four-word look-ahead that the paired word needs, so no pair leaves during them. A one-cycle `done` pulse follows the final pair. A new `load` at any time abandons the current run and starts over with the new block.

Top module: `sm3_msg_expand`

## Requirements
- R1: Word W0 is `block_in[511:480]`, W1 is `block_in[479:448]`, and so on down to W15 = `block_in[31:0]`. Pairs 0..15 carry these words on `wj`.
- R2: For 16 <= j <= 67, Wj = P1(Wj-16 ^ Wj-9 ^ rol(Wj-3,15)) ^ rol(Wj-13,7) ^ Wj-6, where P1(x) = x ^ rol(x,15) ^ rol(x,23) and rol is a 32-bit left rotation. Pairs 16..63 carry W16..W63 on `wj`.
- R3: With each valid pair j, `wpj` equals Wj ^ Wj+4 for 0 <= j <= 63.
- R4: After the clock edge that samples `load` high, `out_valid` stays low for four cycles. Pair 0 is visible after the fifth following edge.
- R5: Exactly 64 valid pairs leave on consecutive cycles with indices 0..63 in order. `out_valid` then stays low until the next load.
- R6: `done` is high for exactly one cycle, the cycle right after the cycle that carries pair 63. `out_valid` is low in that cycle.
- R7: While `rst_n` is low, `out_valid` and `done` are low.
- R8: A `load` that arrives during a run discards that run. The output sequence restarts as in R4 with the new block.
- R9: `block_in` is sampled only when `load` is high. Changing it during a run does not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Starts a run with the block on `block_in` |
| block_in | input | 512 | Padded message block, word 0 in the top bits |
| out_valid | output | 1 | `wj` and `wpj` hold a valid pair |
| wj | output | 32 | Expanded word Wj |
| wpj | output | 32 | Paired word Wj ^ Wj+4 |
| done | output | 1 | One-cycle pulse after pair 63 |

## Verification
Two functions can land in the same cycle: a new `load` and the emission of a pair from the running block. The bench provokes this by issuing a second load thirty cycles into a run, while pairs are streaming. The reference model restarts its cycle count at that edge, so every later cycle is judged against the new block's expected sequence: a four-cycle quiet lead, then 64 fresh pairs and one `done`. The bench also scrambles `block_in` after each load. This shows that only the sampled block shapes the stream.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int LAG       = 4;
    localparam int PAIRS     = 64;
    localparam int STEPS     = PAIRS + LAG;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rol(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t perm1(input word_t x);
        return x ^ rol(x, 15) ^ rol(x, 23);
    endfunction
endpackage

// File: rtl/sm3x_recur.sv
module sm3x_recur
    import sm3x_pkg::*;
(
    input  word_t t16,
    input  word_t t13,
    input  word_t t9,
    input  word_t t6,
    input  word_t t3,
    output word_t w_new
);
    word_t mix;

    always_comb begin
        mix   = t16 ^ t9 ^ rol(t3, 15);
        w_new = perm1(mix) ^ rol(t13, 7) ^ t6;
    end
endmodule

// File: rtl/sm3x_ctrl.sv
module sm3x_ctrl
    import sm3x_pkg::*;
#(
    parameter int N_STEPS = STEPS,
    parameter int N_LAG   = LAG,
    parameter int N_BLK   = BLK_WORDS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic emit,
    output logic gen_phase,
    output logic done
);
    localparam int SW = $clog2(N_STEPS);

    typedef struct packed {
        logic          busy;
        logic [SW-1:0] step;
        logic          fin1;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic last;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.fin1 = 1'b0;
        ctl_d.done = ctl_q.fin1 & ~load;
        if (load) begin
            ctl_d.busy = 1'b1;
            ctl_d.step = '0;
        end else if (ctl_q.busy) begin
            if (last) begin
                ctl_d.busy = 1'b0;
                ctl_d.step = '0;
                ctl_d.fin1 = 1'b1;
            end else begin
                ctl_d.step = ctl_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign last      = ctl_q.busy && (ctl_q.step == SW'(N_STEPS - 1));
    assign busy      = ctl_q.busy;
    assign emit      = ctl_q.busy && (ctl_q.step >= SW'(N_LAG));
    assign gen_phase = ctl_q.busy && (ctl_q.step >= SW'(N_BLK));
    assign done      = ctl_q.done;

    // R5: step counter never runs past the final step
    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.busy |-> (ctl_q.step <= SW'(N_STEPS - 1)));

    // R5: once emitting, emission continues until the final step
    a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !last && !load) |=> emit);
endmodule

// File: rtl/sm3_msg_expand.sv
module sm3_msg_expand
    import sm3x_pkg::*;
#(
    parameter int N_WORDS = BLK_WORDS,
    parameter int N_LAG   = LAG,
    parameter int N_PAIRS = PAIRS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [WORD_W*N_WORDS-1:0]   block_in,
    output logic                        out_valid,
    output logic [WORD_W-1:0]           wj,
    output logic [WORD_W-1:0]           wpj,
    output logic                        done
);
    localparam int BLK_W   = WORD_W * N_WORDS;
    localparam int N_STEPS = N_PAIRS + N_LAG;
    localparam int PAIR_AT = N_WORDS - N_LAG;

    typedef struct packed {
        logic [N_WORDS-1:0][WORD_W-1:0] win;
        logic                           valid;
        word_t                          wj;
        word_t                          wpj;
    } dp_t;

    dp_t   dp_d, dp_q;
    logic  busy, emit, gen_phase;
    word_t w_new, produced;

    sm3x_ctrl #(
        .N_STEPS (N_STEPS),
        .N_LAG   (N_LAG),
        .N_BLK   (N_WORDS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .busy      (busy),
        .emit      (emit),
        .gen_phase (gen_phase),
        .done      (done)
    );

    sm3x_recur u_recur (
        .t16   (dp_q.win[N_WORDS-16]),
        .t13   (dp_q.win[N_WORDS-13]),
        .t9    (dp_q.win[N_WORDS-9]),
        .t6    (dp_q.win[N_WORDS-6]),
        .t3    (dp_q.win[N_WORDS-3]),
        .w_new (w_new)
    );

    always_comb begin
        produced    = gen_phase ? w_new : dp_q.win[0];
        dp_d        = dp_q;
        dp_d.valid  = 1'b0;
        if (load) begin
            for (int i = 0; i < N_WORDS; i++)
                dp_d.win[i] = block_in[BLK_W-1-i*WORD_W -: WORD_W];
        end else if (busy) begin
            for (int i = 0; i < N_WORDS-1; i++)
                dp_d.win[i] = dp_q.win[i+1];
            dp_d.win[N_WORDS-1] = produced;
            if (emit) begin
                dp_d.valid = 1'b1;
                dp_d.wj    = dp_q.win[PAIR_AT];
                dp_d.wpj   = dp_q.win[PAIR_AT] ^ produced;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign out_valid = dp_q.valid;
    assign wj        = dp_q.wj;
    assign wpj       = dp_q.wpj;

    // R4, R8: the cycle after a load edge never carries a pair
    a_r4_quiet_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> !out_valid);

    // R6: done follows a valid pair and never overlaps one
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && !out_valid));

    // R6: done is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: reset leaves outputs quiet
    a_r7_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !done));
endmodule

// File: tb/test_sm3_msg_expand.sv
module test_sm3_msg_expand;
    timeunit 1ns;
    timeprecision 100ps;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         load;
    logic [511:0] block_in;
    logic         out_valid;
    logic [31:0]  wj;
    logic [31:0]  wpj;
    logic         done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string note = "";

    logic [31:0] ref_w [0:67];
    int          n_since = -1;

    always #2.5 clk = ~clk;

    sm3_msg_expand i_sm3_msg_expand (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .block_in  (block_in),
        .out_valid (out_valid),
        .wj        (wj),
        .wpj       (wpj),
        .done      (done)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, note, act, exp);
        end
    endtask

    // reference model: cycle count since the last sampled load
    always @(posedge clk) begin
        if (!rst_n) begin
            n_since = -1;
        end else if (load) begin
            for (int k = 0; k < 16; k++)
                ref_w[k] = block_in[511-32*k -: 32];
            for (int k = 16; k < 68; k++) begin
                logic [31:0] x;
                x = ref_w[k-16] ^ ref_w[k-9] ^ rl(ref_w[k-3], 15);
                ref_w[k] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(ref_w[k-13], 7) ^ ref_w[k-6];
            end
            n_since = 0;
        end else if (n_since >= 0 && n_since < 1000) begin
            n_since++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && n_since >= 0 && !finished) begin
            bit exp_v;
            bit exp_d;
            int j;
            exp_v = (n_since >= 5) && (n_since <= 68);
            exp_d = (n_since == 69);
            j = n_since - 5;
            chk(out_valid == exp_v, "R4/R5 valid", 32'(out_valid), 32'(exp_v));
            chk(done == exp_d, "R6 done", 32'(done), 32'(exp_d));
            if (exp_v && out_valid) begin
                chk(wj == ref_w[j], (j < 16) ? "R1 wj" : "R2 wj", wj, ref_w[j]);
                chk(wpj == (ref_w[j] ^ ref_w[j+4]), "R3 wpj", wpj, ref_w[j] ^ ref_w[j+4]);
            end
        end
    end

    task automatic pulse_load(input logic [511:0] blk);
        block_in = blk;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        logic [511:0] blk;
        rst_n = 1'b0;
        load = 1'b0;
        block_in = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R7 reset valid", 32'(out_valid), 32'h0);
        chk(done == 1'b0, "R7 reset done", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // padded three-byte message
        blk = '0;
        blk[511:480] = 32'h6162_6380;
        blk[31:0] = 32'h0000_0018;
        note = "R9 block_in scrambled";
        pulse_load(blk);
        block_in = {16{32'hDEAD_BEEF}};
        repeat (78) @(negedge clk);

        // incrementing words, then a restart in mid-run
        note = "";
        for (int k = 0; k < 16; k++)
            blk[511-32*k -: 32] = 32'h0101_0101 * (k + 1);
        pulse_load(blk);
        repeat (30) @(negedge clk);
        for (int k = 0; k < 16; k++)
            blk[511-32*k -: 32] = (k % 2 == 0) ? 32'hA5A5_5A5A : 32'hFFFF_FFFF;
        note = "R8 restart";
        pulse_load(blk);
        repeat (78) @(negedge clk);

        note = "";
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule